// File: doc/BRIEF.md
# HI/LO Multiply-Divide Result Unit

This unit holds the two special result registers of a 32-bit integer core: a high half and a low half. It performs unsigned multiplication and unsigned division and places the results in the pair. It also copies an operand into either half and returns either half on a read-data port. It remembers whether a computed result has been collected yet. A move into one half made before that collection marks the opposite half as unpredictable.

An operation is presented with `start_i`, a 3-bit code and two operands. It is accepted on a rising clock edge while `busy_o` is low. A request made while `busy_o` is high is not taken. The requester holds it, and it is accepted on the first edge after `busy_o` falls. Division takes one quotient bit per cycle. The multiplier is either a single-cycle array or a shift-add loop that takes one bit per cycle, selected by a parameter.

Top module: `hilo_unit`

## Requirements
- R1: After reset both halves read as zero, `busy_o`, `rvalid_o`, `hi_bad_o` and `lo_bad_o` are low, and no computed result is pending.
- R2: Op code 0 (unsigned multiply) writes the low `DATA_W` bits of `opa_i*opb_i` to the low half and the upper `DATA_W` bits to the high half. In the single-cycle build the result is present after the accepting edge.
- R3: Op code 1 (unsigned divide) puts `opa_i/opb_i` in the low half and `opa_i%opb_i` in the high half. `busy_o` is high for exactly `DATA_W` cycles after the accepting edge.
- R4: A divide with `opb_i` zero completes in the same time, with all ones in the low half and the dividend in the high half.
- R5: Op code 2 copies `opa_i` into the high half, and op code 3 copies `opa_i` into the low half, unchanged.
- R6: Op code 4 (read high) and op code 5 (read low) drive the half's content on `rdata_o` with `rvalid_o` high in the cycle after acceptance. They also mark any pending computed result as collected.
- R7: Op code 2 accepted while a computed result is pending sets `lo_bad_o`, and op code 3 in that state sets `hi_bad_o`. The flagged half keeps its old content.
- R8: While `busy_o` is high no request is accepted. A held request is accepted on the first edge after `busy_o` falls.
- R9: A completed multiply or divide clears both flags. A move into a half clears that half's flag, and moves made with nothing pending raise no flag.
- R10: Any move into a half abandons the pending result, so a second move raises no further flag.
- R11: Op codes 6 and 7 are accepted and change neither half, the flags nor the pending state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation request, held until accepted |
| op_i | input | 3 | Operation code (see R2 to R11) |
| opa_i | input | DATA_W | Multiplicand, dividend or move value |
| opb_i | input | DATA_W | Multiplier or divisor |
| busy_o | output | 1 | Iterative operation in progress; requests not accepted |
| rdata_o | output | DATA_W | Read data from a move-from |
| rvalid_o | output | 1 | `rdata_o` valid this cycle |
| hi_bad_o | output | 1 | High half content is unpredictable |
| lo_bad_o | output | 1 | Low half content is unpredictable |

## Verification
The bench builds the unit with `DATA_W` = 32 and `MUL_ITERATIVE` = 0. This makes the single-cycle product and the 32-step divide loop the paths under test. At full width, the all-ones multiply, divide by zero and divides with large quotients test the carry out of the top product bit and the final restoring step. A reference model tracks the busy window and the pending and flag state through directed and random operation streams.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

   typedef enum logic [2:0] {
      OP_MULU   = 3'd0,
      OP_DIVU   = 3'd1,
      OP_TOHI   = 3'd2,
      OP_TOLO   = 3'd3,
      OP_FROMHI = 3'd4,
      OP_FROMLO = 3'd5,
      OP_NOP6   = 3'd6,
      OP_NOP7   = 3'd7
   } hilo_op_e;

endpackage

// File: rtl/hilo_div.sv
module hilo_div #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W-1:0] dvd_i,
   input  logic [W-1:0] dvs_i,
   output logic         busy_o,
   output logic         done_o,
   output logic [W-1:0] quo_o,
   output logic [W-1:0] rem_o
);
   localparam int CW = $clog2(W + 1);

   logic [CW-1:0] cnt_q;
   logic [W-1:0]  quo_q, rem_q, dvs_q, orig_q;
   logic          zero_q;
   logic [W:0]    shifted, diff;
   logic          fits;
   logic [W-1:0]  quo_n, rem_n;

   always_comb begin
      shifted = {rem_q, quo_q[W-1]};
      diff    = shifted - {1'b0, dvs_q};
      fits    = ~diff[W];
      rem_n   = fits ? diff[W-1:0] : shifted[W-1:0];
      quo_n   = {quo_q[W-2:0], fits};
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CW'(1));
   assign quo_o  = quo_n;
   assign rem_o  = rem_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         quo_q  <= '0;
         rem_q  <= '0;
         dvs_q  <= '0;
         orig_q <= '0;
         zero_q <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= CW'(W);
         quo_q  <= dvd_i;
         rem_q  <= '0;
         dvs_q  <= dvs_i;
         orig_q <= dvd_i;
         zero_q <= (dvs_i == '0);
      end else if (busy_o) begin
         cnt_q <= cnt_q - CW'(1);
         quo_q <= quo_n;
         rem_q <= rem_n;
      end
   end

   // R4: zero divisor gives all-ones quotient, dividend as remainder
   p_zero_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && zero_q) |-> (quo_o == '1 && rem_o == orig_q));
   // R3: an accepted divide makes the unit busy on the next cycle
   p_div_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> busy_o);
   // R8: no new divide is launched while one is running
   p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> !start_i);
endmodule

// File: rtl/hilo_mul.sv
module hilo_mul #(
   parameter int W    = 32,
   parameter int ITER = 0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic           busy_o,
   output logic           done_o,
   output logic [2*W-1:0] prod_o
);
   localparam int PW = 2 * W;
   localparam int CW = $clog2(W + 1);

   generate
      if (ITER == 0) begin : g_array
         assign prod_o = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
         assign busy_o = 1'b0;
         assign done_o = start_i;

         // R2: product parity bit matches the operands' low bits
         p_low_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |-> (prod_o[0] == (a_i[0] & b_i[0])));
      end else begin : g_shift_add
         logic [CW-1:0] cnt_q;
         logic [PW-1:0] acc_q, acc_n;
         logic [W-1:0]  mcd_q;
         logic [W:0]    sum;

         always_comb begin
            sum   = {1'b0, acc_q[PW-1:W]} + (acc_q[0] ? {1'b0, mcd_q} : '0);
            acc_n = {sum, acc_q[W-1:1]};
         end

         assign busy_o = (cnt_q != '0);
         assign done_o = (cnt_q == CW'(1));
         assign prod_o = acc_n;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               acc_q <= '0;
               mcd_q <= '0;
            end else if (start_i) begin
               cnt_q <= CW'(W);
               acc_q <= {{W{1'b0}}, b_i};
               mcd_q <= a_i;
            end else if (busy_o) begin
               cnt_q <= cnt_q - CW'(1);
               acc_q <= acc_n;
            end
         end

         // R2: the loop ends and releases busy after its final step
         p_mul_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
            done_o |=> !busy_o);
      end
   endgenerate
endmodule

// File: rtl/hilo_regs.sv
module hilo_regs
   import hilo_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         res_we_i,
   input  logic [W-1:0] res_hi_i,
   input  logic [W-1:0] res_lo_i,
   input  logic         op_we_i,
   input  hilo_op_e     op_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] rdata_o,
   output logic         rvalid_o,
   output logic         hi_bad_o,
   output logic         lo_bad_o
);
   logic [W-1:0] hi_q, lo_q;
   logic         pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= '0;
         lo_q     <= '0;
         pend_q   <= 1'b0;
         hi_bad_o <= 1'b0;
         lo_bad_o <= 1'b0;
         rdata_o  <= '0;
         rvalid_o <= 1'b0;
      end else begin
         rvalid_o <= 1'b0;
         if (res_we_i) begin
            hi_q     <= res_hi_i;
            lo_q     <= res_lo_i;
            pend_q   <= 1'b1;
            hi_bad_o <= 1'b0;
            lo_bad_o <= 1'b0;
         end else if (op_we_i) begin
            unique case (op_i)
               OP_TOHI: begin
                  hi_q     <= val_i;
                  hi_bad_o <= 1'b0;
                  if (pend_q) lo_bad_o <= 1'b1;
                  pend_q   <= 1'b0;
               end
               OP_TOLO: begin
                  lo_q     <= val_i;
                  lo_bad_o <= 1'b0;
                  if (pend_q) hi_bad_o <= 1'b1;
                  pend_q   <= 1'b0;
               end
               OP_FROMHI: begin
                  rdata_o  <= hi_q;
                  rvalid_o <= 1'b1;
                  pend_q   <= 1'b0;
               end
               OP_FROMLO: begin
                  rdata_o  <= lo_q;
                  rvalid_o <= 1'b1;
                  pend_q   <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

   // R7: move into high while a result is pending spoils the low half
   p_tohi_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_we_i && !res_we_i && op_i == OP_TOHI && pend_q) |=> lo_bad_o);
   // R7: move into low while a result is pending spoils the high half
   p_tolo_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_we_i && !res_we_i && op_i == OP_TOLO && pend_q) |=> hi_bad_o);
   // R9: a fresh computed result clears both flags
   p_fresh_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_we_i |=> (!hi_bad_o && !lo_bad_o));
   // R6: a read of the high half returns it on the next cycle
   p_read_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_we_i && !res_we_i && op_i == OP_FROMHI) |=> (rvalid_o && rdata_o == $past(hi_q)));
endmodule

// File: rtl/hilo_unit.sv
module hilo_unit
   import hilo_pkg::*;
#(
   parameter int DATA_W        = 32,
   parameter int MUL_ITERATIVE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   output logic              busy_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   output logic              hi_bad_o,
   output logic              lo_bad_o
);
   localparam int PROD_W = 2 * DATA_W;

   initial begin
      assert (DATA_W >= 2) else $fatal(1, "hilo_unit: DATA_W must be at least 2");
      assert (MUL_ITERATIVE == 0 || MUL_ITERATIVE == 1)
         else $fatal(1, "hilo_unit: MUL_ITERATIVE must be 0 or 1");
   end

   hilo_op_e          op;
   logic              accept, mul_go, div_go;
   logic              mul_busy, mul_done, div_busy, div_done;
   logic [PROD_W-1:0] prod;
   logic [DATA_W-1:0] quo, rem;
   logic              res_we;
   logic [DATA_W-1:0] res_hi, res_lo;

   assign op     = hilo_op_e'(op_i);
   assign busy_o = mul_busy | div_busy;
   assign accept = start_i & ~busy_o;
   assign mul_go = accept & (op == OP_MULU);
   assign div_go = accept & (op == OP_DIVU);

   hilo_mul #(.W(DATA_W), .ITER(MUL_ITERATIVE)) u_mul (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (mul_go),
      .a_i     (opa_i),
      .b_i     (opb_i),
      .busy_o  (mul_busy),
      .done_o  (mul_done),
      .prod_o  (prod)
   );

   hilo_div #(.W(DATA_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_go),
      .dvd_i   (opa_i),
      .dvs_i   (opb_i),
      .busy_o  (div_busy),
      .done_o  (div_done),
      .quo_o   (quo),
      .rem_o   (rem)
   );

   assign res_we = mul_done | div_done;
   assign res_hi = div_done ? rem : prod[PROD_W-1:DATA_W];
   assign res_lo = div_done ? quo : prod[DATA_W-1:0];

   hilo_regs #(.W(DATA_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .res_we_i (res_we),
      .res_hi_i (res_hi),
      .res_lo_i (res_lo),
      .op_we_i  (accept),
      .op_i     (op),
      .val_i    (opa_i),
      .rdata_o  (rdata_o),
      .rvalid_o (rvalid_o),
      .hi_bad_o (hi_bad_o),
      .lo_bad_o (lo_bad_o)
   );

   // R8: busy only rises as a consequence of an accepted request
   p_busy_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !accept) |=> !busy_o);
   // R3: the two engines never run together
   p_one_engine_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(mul_busy && div_busy));
endmodule

// File: tb/hilo_unit_bench.sv
`timescale 1ns/1ps
module hilo_unit_bench;
   localparam int W       = 32;
   localparam int MI      = 0;
   localparam int MUL_LAT = (MI != 0) ? W : 0;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic [2:0]   op_i = 3'd0;
   logic [W-1:0] opa_i = '0, opb_i = '0;
   logic         busy_o, rvalid_o, hi_bad_o, lo_bad_o;
   logic [W-1:0] rdata_o;

   always #2 clk = ~clk;

   hilo_unit #(.DATA_W(W), .MUL_ITERATIVE(MI)) u_hilo_unit (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .rdata_o(rdata_o),
      .rvalid_o(rvalid_o), .hi_bad_o(hi_bad_o), .lo_bad_o(lo_bad_o)
   );

   int    checks = 0, errors = 0, cyc = 0;
   bit    finished = 1'b0;
   string cur_tag = "R1";

   // reference model
   logic [W-1:0]   m_hi, m_lo, m_rd, p_hi, p_lo;
   logic [2*W-1:0] m_prod;
   bit             m_pend, m_hb, m_lb, m_rv;
   int             m_cnt;

   task automatic commit();
      m_hi = p_hi; m_lo = p_lo; m_pend = 1; m_hb = 0; m_lb = 0;
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_hi = '0; m_lo = '0; m_rd = '0; m_pend = 0; m_hb = 0; m_lb = 0;
         m_rv = 0; m_cnt = 0;
      end else begin
         m_rv = 0;
         if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) commit();
         end else if (start_i) begin
            case (op_i)
               3'd0: begin
                  m_prod = {{W{1'b0}}, opa_i} * {{W{1'b0}}, opb_i};
                  p_hi = m_prod[2*W-1:W]; p_lo = m_prod[W-1:0];
                  if (MUL_LAT == 0) commit(); else m_cnt = MUL_LAT;
               end
               3'd1: begin
                  if (opb_i == '0) begin p_lo = '1; p_hi = opa_i; end
                  else begin p_lo = opa_i / opb_i; p_hi = opa_i % opb_i; end
                  m_cnt = W;
               end
               3'd2: begin m_hi = opa_i; m_hb = 0; if (m_pend) m_lb = 1; m_pend = 0; end
               3'd3: begin m_lo = opa_i; m_lb = 0; if (m_pend) m_hb = 1; m_pend = 0; end
               3'd4: begin m_rd = m_hi; m_rv = 1; m_pend = 0; end
               3'd5: begin m_rd = m_lo; m_rv = 1; m_pend = 0; end
               default: ;
            endcase
         end
      end
   end

   task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // cycle-by-cycle comparison with the model
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R3", W'(busy_o), W'(m_cnt > 0));
         check(cur_tag, W'(rvalid_o), W'(m_rv));
         if (m_rv) check(cur_tag, rdata_o, m_rd);
         check(cur_tag, W'(hi_bad_o), W'(m_hb));
         check(cur_tag, W'(lo_bad_o), W'(m_lb));
      end
   end

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cyc);
         summary();
         $finish;
      end
   end

   // request held until accepted; returns at the negedge after the accepting edge
   task automatic issue(logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b, string tag);
      @(negedge clk);
      cur_tag = tag;
      start_i = 1'b1; op_i = op; opa_i = a; opb_i = b;
      while (busy_o) @(negedge clk);
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy_o) @(negedge clk);
   endtask

   task automatic expect_read(logic [2:0] op, logic [W-1:0] exp, string tag);
      issue(op, '0, '0, tag);
      check(tag, W'(rvalid_o), W'(1));
      check(tag, rdata_o, exp);
   endtask

   initial begin
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", W'(busy_o), '0);
      check("R1", W'(rvalid_o), '0);
      check("R1", W'({hi_bad_o, lo_bad_o}), '0);
      rst_n = 1'b1;
      expect_read(3'd4, '0, "R1");
      expect_read(3'd5, '0, "R1");

      // R5 moves
      issue(3'd2, 32'h1234_5678, '0, "R5");
      issue(3'd3, 32'h9abc_def0, '0, "R5");
      expect_read(3'd4, 32'h1234_5678, "R5");
      expect_read(3'd5, 32'h9abc_def0, "R5");

      // R2 multiply
      issue(3'd0, 32'hffff_ffff, 32'hffff_ffff, "R2");
      wait_idle();
      expect_read(3'd4, 32'hffff_fffe, "R2");
      expect_read(3'd5, 32'h0000_0001, "R2");
      issue(3'd0, 32'h0001_0000, 32'h0003_0000, "R2");
      wait_idle();
      expect_read(3'd5, 32'h0, "R2");
      expect_read(3'd4, 32'h3, "R2");

      // R3 divide and busy length
      issue(3'd1, 32'd100, 32'd7, "R3");
      n = 0;
      while (busy_o) begin n++; @(negedge clk); end
      check("R3", W'(n), W'(W));
      expect_read(3'd5, 32'd14, "R3");
      expect_read(3'd4, 32'd2, "R3");

      // R8 read held while busy
      issue(3'd1, 32'hdead_beef, 32'h10, "R8");
      expect_read(3'd5, 32'h0dea_dbee, "R8");
      expect_read(3'd4, 32'hf, "R8");

      // R4 divide by zero
      issue(3'd1, 32'h1357_9bdf, 32'h0, "R4");
      expect_read(3'd5, 32'hffff_ffff, "R4");
      expect_read(3'd4, 32'h1357_9bdf, "R4");

      // R7 move into high while pending
      issue(3'd1, 32'd50, 32'd3, "R7");
      wait_idle();
      issue(3'd2, 32'h0000_aaaa, '0, "R7");
      check("R7", W'(lo_bad_o), W'(1));
      check("R7", W'(hi_bad_o), W'(0));
      expect_read(3'd4, 32'h0000_aaaa, "R5");
      expect_read(3'd5, 32'd16, "R7");

      // R7 / R10 / R9 move into low while pending, then second move
      issue(3'd0, 32'd5, 32'd6, "R7");
      issue(3'd3, 32'd7, '0, "R7");
      check("R7", W'(hi_bad_o), W'(1));
      issue(3'd2, 32'd8, '0, "R10");
      check("R9", W'(hi_bad_o), W'(0));
      check("R10", W'(lo_bad_o), W'(0));
      expect_read(3'd5, 32'd7, "R10");

      // R9 no flag after read; new result clears
      issue(3'd0, 32'd9, 32'd9, "R9");
      check("R9", W'({hi_bad_o, lo_bad_o}), '0);
      expect_read(3'd4, 32'd0, "R9");
      issue(3'd3, 32'd1, '0, "R9");
      check("R9", W'(hi_bad_o), W'(0));

      // R11 reserved codes keep pending state and contents
      issue(3'd0, 32'd2, 32'd3, "R11");
      issue(3'd6, 32'hffff_ffff, 32'hffff_ffff, "R11");
      issue(3'd7, 32'h5555_5555, 32'h1, "R11");
      check("R11", W'({hi_bad_o, lo_bad_o}), '0);
      issue(3'd2, 32'd4, '0, "R11");
      check("R11", W'(lo_bad_o), W'(1));
      expect_read(3'd5, 32'd6, "R11");

      // random stream against the model
      for (int i = 0; i < 400; i++) begin
         logic [2:0]   rop;
         logic [W-1:0] ra, rb;
         string        t;
         rop = 3'($urandom_range(0, 7));
         ra  = $urandom;
         rb  = (i % 7 == 0) ? '0 : ((i % 3 == 0) ? W'($urandom_range(1, 300)) : $urandom);
         case (rop)
            3'd0: t = "R2";
            3'd1: t = "R3";
            3'd2, 3'd3: t = "R7";
            3'd4, 3'd5: t = "R6";
            default: t = "R11";
         endcase
         issue(rop, ra, rb, t);
      end
      wait_idle();
      @(negedge clk);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule